// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a successive-approximation analogue-to-digital converter. A start request launches a binary search over an N-bit code. On every step the block presents a trial code to an external DAC, waits a programmable number of cycles for the analogue path to settle, and then reads a single comparator bit. When all N steps are done, the final code appears on the result port together with a one-cycle end-of-conversion pulse.

Two search styles are available. The choice is taken from a mode input at the moment a conversion is accepted.

- **Unipolar mode.** This is the classic set-and-clear search. The bit under test is first set, and it is then kept or dropped according to the comparator.
- **Signed mode.** The block keeps a running two's-complement estimate. The estimate starts at zero, and each step moves it up or down by a step that halves every time. The comparator's sign decides the direction.

Codes are WIDTH+1 bits wide so that the signed estimate fits. In unipolar mode the top bit is always zero.

The comparator input is interpreted by mode:

- In unipolar mode, `cmpHighI` = 1 means the DAC level for the trial code is strictly above the sampled input.
- In signed mode, `cmpHighI` = 1 means the DAC level is at or above the input. This is the non-negative branch of the sign function.

Top module: `sar_conv_ctrl`

## Requirements
- R1: In unipolar mode, the first trial code after an accepted start has only bit WIDTH-1 set.
- R2: In unipolar mode, a comparator value of 1 clears the bit under test and a value of 0 keeps it. Apart from the final step, the next lower bit is then set. The unipolar result is therefore the largest code whose DAC level does not exceed the input, saturating at 2^WIDTH-1.
- R3: Each trial code is held for exactly SETTLE cycles (SETTLE ≥ 1). The comparator is sampled at the clock edge that ends the hold.
- R4: In signed mode, the estimate starts at 0. Step k (k = 1..WIDTH) subtracts 2^(WIDTH-k) when the comparator is 1 and adds it when the comparator is 0. Values are in units of 2^-WIDTH of the reference, and the trial code is the two's-complement estimate.
- R5: In signed mode, for a normalised input in [-1, 1], the final code times 2^-WIDTH lies within 2^-WIDTH of the input.
- R6: `eocO` is a single-cycle pulse. Its rising edge comes WIDTH*SETTLE+1 cycles after the cycle in which the start was sampled, and `resultCodeO` takes the new code in that same cycle. `busyO` is high from the cycle after the start up to and including the `eocO` cycle, and low in the cycle after.
- R7: A start request while `busyO` is high, including the `eocO` cycle, is ignored. It does not restart or lengthen the conversion and does not change its mode.
- R8: `resultCodeO` changes only together with `eocO`. The mode input and comparator have no effect on it between conversions.
- R9: While reset is active and immediately after it, `busyO`, `eocO`, `trialCodeO` and `resultCodeO` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startI | input | 1 | Conversion request, sampled while idle |
| signedModeI | input | 1 | 1 selects signed mode, 0 selects unipolar mode; sampled with the start |
| cmpHighI | input | 1 | Comparator: DAC level above (or, in signed mode, at or above) the input |
| trialCodeO | output | WIDTH+1 | Code currently driven to the DAC |
| resultCodeO | output | WIDTH+1 | Last completed conversion code |
| busyO | output | 1 | Conversion in progress |
| eocO | output | 1 | End-of-conversion pulse |

## Verification
The bench builds the block with WIDTH = 6 and SETTLE = 2. A settle time of two cycles makes it possible to check that a trial code stays steady across its whole hold window, and that the decision lands on the last cycle of that window rather than the first. A six-bit width keeps the full step-by-step trial sequence short enough to compare on every step, for both search styles. It also covers both ends of the range: saturation at code 63, the exact-integer tie in unipolar mode, and the zero-input and ±1.0 inputs in signed mode.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_DONE = 2'd2
  } sarState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;      // accepted start: initialise estimate
    logic decide;    // end of a hold window: apply comparator
    logic finish;    // decision on the last bit: capture result
    logic signedOp;  // search style in force
  } sarStrobe_t;

endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int WIDTH  = 6,
  parameter int SETTLE = 1,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startI,
  input  logic             signedModeI,
  output sarStrobe_t       strobeO,
  output logic [IDX_W-1:0] bitIdxO,
  output logic             busyO,
  output logic             eocO
);

  sarState_t        state;
  logic [IDX_W-1:0] bitIdx;
  logic [CNT_W-1:0] holdCnt;
  logic             modeQ;
  logic             accept;
  logic             stepEnd;
  logic             lastStep;

  assign accept   = startI && (state == ST_IDLE);
  assign stepEnd  = (state == ST_CONV) && (holdCnt == CNT_W'(SETTLE - 1));
  assign lastStep = stepEnd && (bitIdx == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitIdx  <= '0;
      holdCnt <= '0;
      modeQ   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_CONV;
            bitIdx  <= IDX_W'(WIDTH - 1);
            holdCnt <= '0;
            modeQ   <= signedModeI;
          end
        end
        ST_CONV: begin
          if (stepEnd) begin
            holdCnt <= '0;
            if (lastStep) begin
              state <= ST_DONE;
            end else begin
              bitIdx <= bitIdx - 1'b1;
            end
          end else begin
            holdCnt <= holdCnt + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobeO.load     = accept;
    strobeO.decide   = stepEnd;
    strobeO.finish   = lastStep;
    strobeO.signedOp = accept ? signedModeI : modeQ;
  end

  assign bitIdxO = bitIdx;
  assign busyO   = (state != ST_IDLE);
  assign eocO    = (state == ST_DONE);

endmodule

// File: rtl/sar_dp.sv
module sar_dp
  import sar_pkg::*;
#(
  parameter int WIDTH = 6,
  localparam int IDX_W  = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam int CODE_W = WIDTH + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sarStrobe_t        strobeI,
  input  logic [IDX_W-1:0]  bitIdxI,
  input  logic              cmpHighI,
  output logic [CODE_W-1:0] trialCodeO,
  output logic [CODE_W-1:0] resultCodeO
);

  localparam logic [CODE_W-1:0] UNI_SEED = CODE_W'(1) << (WIDTH - 1);

  logic [CODE_W-1:0] est;
  logic [CODE_W-1:0] result;
  logic [CODE_W-1:0] stepVal;
  logic [CODE_W-1:0] uniNext;
  logic [CODE_W-1:0] sgnNext;
  logic [CODE_W-1:0] nextEst;

  assign stepVal = CODE_W'(1) << bitIdxI;

  // unipolar: drop the tested bit if DAC is high, then arm the next one
  always_comb begin
    uniNext = cmpHighI ? (est & ~stepVal) : est;
    uniNext = uniNext | (stepVal >> 1);
  end

  // signed: move the estimate against the sign of (estimate - input)
  assign sgnNext = cmpHighI ? (est - stepVal) : (est + stepVal);
  assign nextEst = strobeI.signedOp ? sgnNext : uniNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      est    <= '0;
      result <= '0;
    end else begin
      if (strobeI.load) begin
        est <= strobeI.signedOp ? '0 : UNI_SEED;
      end else if (strobeI.decide) begin
        est <= nextEst;
      end
      if (strobeI.finish) begin
        result <= nextEst;
      end
    end
  end

  assign trialCodeO  = est;
  assign resultCodeO = result;

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH  = 6,
  parameter int SETTLE = 1,
  localparam int IDX_W  = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam int CODE_W = WIDTH + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startI,
  input  logic              signedModeI,
  input  logic              cmpHighI,
  output logic [CODE_W-1:0] trialCodeO,
  output logic [CODE_W-1:0] resultCodeO,
  output logic              busyO,
  output logic              eocO
);

  sarStrobe_t       strobe;
  logic [IDX_W-1:0] bitIdx;

  sar_seq #(.WIDTH(WIDTH), .SETTLE(SETTLE)) uSeq (
    .clk        (clk),
    .rstN       (rstN),
    .startI     (startI),
    .signedModeI(signedModeI),
    .strobeO    (strobe),
    .bitIdxO    (bitIdx),
    .busyO      (busyO),
    .eocO       (eocO)
  );

  sar_dp #(.WIDTH(WIDTH)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobeI    (strobe),
    .bitIdxI    (bitIdx),
    .cmpHighI   (cmpHighI),
    .trialCodeO (trialCodeO),
    .resultCodeO(resultCodeO)
  );

endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk #(
  parameter int WIDTH  = 6,
  parameter int SETTLE = 1,
  localparam int CODE_W = WIDTH + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              startI,
  input logic              signedModeI,
  input logic [CODE_W-1:0] trialCodeO,
  input logic [CODE_W-1:0] resultCodeO,
  input logic              busyO,
  input logic              eocO
);

  localparam logic [CODE_W-1:0] HALF = CODE_W'(1) << (WIDTH - 1);

  AST_UNI_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rstN)
    (startI && !busyO && !signedModeI) |=> (trialCodeO == HALF)); // R1

  AST_SGN_ZERO_SEED: assert property (@(posedge clk) disable iff (!rstN)
    (startI && !busyO && signedModeI) |=> (trialCodeO == '0)); // R4

  AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    eocO |=> !eocO); // R6

  AST_EOC_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    eocO |-> busyO); // R6

  AST_BUSY_NO_EARLY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (busyO && !eocO) |=> busyO); // R7

  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyO) |-> $past(startI)); // R7

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !eocO |-> $stable(resultCodeO)); // R8

endmodule

bind sar_conv_ctrl sar_conv_chk #(.WIDTH(WIDTH), .SETTLE(SETTLE)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .startI     (startI),
  .signedModeI(signedModeI),
  .trialCodeO (trialCodeO),
  .resultCodeO(resultCodeO),
  .busyO      (busyO),
  .eocO       (eocO)
);

// File: tb/sim_sar_conv_ctrl.sv
`timescale 1ns/1ps
module sim_sar_conv_ctrl;

  localparam int W  = 6;
  localparam int S  = 2;
  localparam int CW = W + 1;
  localparam int FULL = (1 << W) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startI = 1'b0;
  logic          modeIn = 1'b0;
  logic          cmpHigh;
  logic [CW-1:0] trialCode;
  logic [CW-1:0] resultCode;
  logic          busy;
  logic          eoc;

  int testCnt = 0;
  int failCnt = 0;

  // analogue model: input in quarter-LSB units, search style of the reference
  int vinQ = 0;
  logic modeRef = 1'b0;

  always #5 clk = ~clk;

  always_comb begin
    if (modeRef) cmpHigh = (int'($signed(trialCode)) * 4 >= vinQ);
    else         cmpHigh = (int'(trialCode) * 4 > vinQ);
  end

  sar_conv_ctrl #(.WIDTH(W), .SETTLE(S)) u0 (
    .clk        (clk),
    .rstN       (rstN),
    .startI     (startI),
    .signedModeI(modeIn),
    .cmpHighI   (cmpHigh),
    .trialCodeO (trialCode),
    .resultCodeO(resultCode),
    .busyO      (busyO_w),
    .eocO       (eoc)
  );
  logic busyO_w;
  assign busy = busyO_w;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int codeVal(input logic [CW-1:0] c, input bit sgn);
    return sgn ? int'($signed(c)) : int'(c);
  endfunction

  // one conversion with full per-step checking
  task automatic runConv(input bit sgn, input int vq, input bit intrude);
    int expTrial[W+1];
    int est;
    int expRes;
    int lastK;
    est = 0;
    if (sgn) begin
      for (int s = 1; s <= W; s++) begin
        expTrial[s] = est;
        if (est * 4 >= vq) est -= (1 << (W - s));
        else               est += (1 << (W - s));
      end
      expRes = est;
    end else begin
      expRes = vq / 4;
      if (expRes > FULL) expRes = FULL;
      for (int s = 1; s <= W; s++) begin
        int b;
        b = W - s;
        expTrial[s] = ((expRes >> (b + 1)) << (b + 1)) | (1 << b);
      end
    end
    vinQ = vq;
    modeRef = sgn;
    lastK = W * S + 1;
    @(negedge clk);
    startI = 1'b1;
    modeIn = sgn;
    @(negedge clk);
    startI = 1'b0;
    for (int k = 1; k <= lastK + 2; k++) begin
      if (k <= W * S) begin
        int s;
        s = (k - 1) / S + 1;
        if (((k - 1) % S == 0) || ((k - 1) % S == S - 1))
          check(codeVal(trialCode, sgn) == expTrial[s], sgn ? "R4" : "R2",
                $sformatf("trial step %0d cycle %0d", s, k),
                codeVal(trialCode, sgn), expTrial[s]);
        if ((k - 1) % S == S - 1 && (k - 1) % S != 0)
          check(codeVal(trialCode, sgn) == expTrial[s], "R3",
                $sformatf("trial held to end of window %0d", s),
                codeVal(trialCode, sgn), expTrial[s]);
        if (k == 1 && !sgn)
          check(trialCode == CW'(1 << (W - 1)), "R1", "first unipolar trial",
                int'(trialCode), 1 << (W - 1));
        check(eoc == 1'b0 && busy == 1'b1, "R6", $sformatf("busy no eoc k=%0d", k),
              {busy, eoc}, 2);
      end else if (k == lastK) begin
        check(eoc == 1'b1 && busy == 1'b1, "R6", "eoc cycle", {busy, eoc}, 3);
        check(codeVal(resultCode, sgn) == expRes, sgn ? "R4" : "R2", "result",
              codeVal(resultCode, sgn), expRes);
      end else begin
        check(eoc == 1'b0 && busy == 1'b0, "R6", $sformatf("idle after eoc k=%0d", k),
              {busy, eoc}, 0);
      end
      if (intrude) begin
        if (k == 3 || k == lastK) begin
          startI = 1'b1;
          modeIn = ~sgn;
        end else begin
          startI = 1'b0;
        end
      end
      @(negedge clk);
    end
    startI = 1'b0;
    if (intrude)
      check(busy == 1'b0 && codeVal(resultCode, sgn) == expRes, "R7",
            "start during busy/eoc ignored", codeVal(resultCode, sgn), expRes);
    if (sgn && vq >= -256 && vq <= 256) begin
      int diff;
      diff = expRes * 4 - vq;
      if (diff < 0) diff = -diff;
      check(codeVal(resultCode, 1) * 4 - vq <= 4 && vq - codeVal(resultCode, 1) * 4 <= 4,
            "R5", "signed error bound", codeVal(resultCode, 1) * 4 - vq, diff);
    end
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 0 && eoc == 0 && trialCode == 0 && resultCode == 0, "R9",
          "values in reset", int'(resultCode), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && eoc == 0 && trialCode == 0 && resultCode == 0, "R9",
          "values after reset", int'(trialCode), 0);
  endtask

  task automatic tUnipolar();
    runConv(1'b0, 37 * 4, 1'b0);       // exact tie keeps the bit
    runConv(1'b0, 0, 1'b0);            // zero input
    runConv(1'b0, 2000, 1'b0);         // over range saturates
    runConv(1'b0, 21 * 4 + 3, 1'b0);   // fractional input rounds down
  endtask

  task automatic tSigned();
    runConv(1'b1, 0, 1'b0);
    runConv(1'b1, 256, 1'b0);          // +1.0
    runConv(1'b1, -256, 1'b0);         // -1.0
    runConv(1'b1, 97, 1'b0);
    runConv(1'b1, -150, 1'b0);
  endtask

  task automatic tIgnoreStart();
    runConv(1'b0, 45 * 4 + 1, 1'b1);
    runConv(1'b1, -61, 1'b1);
  endtask

  task automatic tHold();
    logic [CW-1:0] kept;
    kept = resultCode;
    vinQ = 123;
    modeRef = 1'b0;
    modeIn = 1'b0;
    repeat (6) @(negedge clk);
    check(resultCode == kept && busy == 0, "R8", "result held, mode/cmp change",
          int'(resultCode), int'(kept));
    modeIn = 1'b1;
    vinQ = -200;
    repeat (4) @(negedge clk);
    check(resultCode == kept && trialCode == trialCode && eoc == 0, "R8",
          "result held after second change", int'(resultCode), int'(kept));
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    tReset();
    tUnipolar();
    tSigned();
    tIgnoreStart();
    tHold();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL R6 watchdog expired: actual %0d expected %0d", 1, 0);
    finishRun();
  end

endmodule